// File: doc/BRIEF.md
# Errored-Event Counter with Threshold Alarms

This block counts two streams of received error events: header-check errors and parity (BIP) errors. Each stream arrives as a one-cycle pulse. Each stream has its own saturating counter and its own programmable threshold. When a counter equals its threshold, the block latches a sticky alarm bit for that stream. Software reads that bit later.

A byte-wide register port gives access to everything. Each counter is read as three bytes at consecutive addresses, with the most significant byte at the lowest address. Reading the most significant byte takes a coherent snapshot of the whole counter and starts a new counting period. The two reads that follow return the remaining bytes of that snapshot. The thresholds are plain read/write bytes. The alarm byte clears when it is read.

Top module: `errcnt_alarm`

## Requirements
- R1: Each cycle with `par_err` high adds one to the parity counter, and each cycle with `hdr_err` high adds one to the header counter; both streams may count in the same cycle.
- R2: A counter never wraps. At all ones (0xFFFFFF for the default width of 24 bits), further pulses leave it unchanged.
- R3: Each counter has three byte addresses: header at 0x2E/0x2F/0x30 and parity at 0x34/0x35/0x36. The lowest address holds bits 23:16 and the highest holds bits 7:0. A read of the lowest address returns the live bits 23:16, copies the whole counter into a snapshot and clears the counter. Reads of the other two addresses return bytes of the snapshot. Read data appears on `reg_rdata` one cycle after the read strobe.
- R4: An error pulse in the same cycle as a clearing read leaves the counter at 1 after that cycle. The snapshot holds the count from before the pulse.
- R5: The thresholds are read/write bytes: header at 0x31/0x32/0x33 and parity at 0x37/0x38/0x39, with the most significant byte at the lowest address. Every threshold byte resets to 0xFF.
- R6: When a counter equals its nonzero threshold, the matching alarm bit is set one cycle later. Bit 1 is the header alarm and bit 0 is the parity alarm. The alarm byte is read at 0x3A.
- R7: An alarm bit stays set until the alarm byte is read. The read returns the bit and clears it, unless the equality still holds in the cycle of that read; in that case the bit stays set.
- R8: A threshold of zero never raises its alarm.
- R9: Alarm bits 7:2 read as zero. Reads of unmapped addresses return 0x00. Writes to counter, alarm or unmapped addresses change nothing.
- R10: After reset, both counters, both snapshots, the alarm byte and `reg_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_err | input | 1 | One-cycle parity error event |
| hdr_err | input | 1 | One-cycle header-check error event |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |

## Verification
Read data is registered, so every read check samples `reg_rdata` shortly after the clock edge that closes the strobe cycle. Counters and thresholds change at that same edge. An alarm lags the counter that matched it by one further edge. The bench drives inputs on the falling edge and advances its reference model of counters, snapshots, thresholds and alarms once per rising edge. It compares each read against the model value from before that edge, so the same latencies apply whatever the stimulus. Saturation runs on a second instance with an 8-bit counter width, which reaches full scale within the run time.

// File: rtl/errcnt_pkg.sv
package errcnt_pkg;

    localparam int NUM_LANES  = 2;
    localparam int LANE_PAR   = 0;
    localparam int LANE_HDR   = 1;
    localparam int REG_BYTES  = 3;
    localparam int WIDE_W     = 8 * REG_BYTES;

    localparam logic [7:0] ALARM_ADDR = 8'h3A;

    // Base (most significant byte) address of each lane's counter.
    function automatic logic [7:0] cnt_base(int lane);
        return (lane == LANE_HDR) ? 8'h2E : 8'h34;
    endfunction

    // Base (most significant byte) address of each lane's threshold.
    function automatic logic [7:0] thr_base(int lane);
        return (lane == LANE_HDR) ? 8'h31 : 8'h37;
    endfunction

    function automatic logic [7:0] byte_of(logic [WIDE_W-1:0] v, int unsigned idx);
        return v[idx*8 +: 8];
    endfunction

endpackage

// File: rtl/errcnt_decode.sv
module errcnt_decode
    import errcnt_pkg::*;
(
    input  logic [7:0]                          reg_addr,
    input  logic                                reg_rd,
    input  logic                                reg_wr,
    output logic [NUM_LANES-1:0][REG_BYTES-1:0] cnt_rd,
    output logic [NUM_LANES-1:0][REG_BYTES-1:0] thr_rd,
    output logic [NUM_LANES-1:0][REG_BYTES-1:0] thr_wr,
    output logic                                alarm_rd
);
    // Byte index REG_BYTES-1 sits at the base address, index 0 at base+REG_BYTES-1.
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        for (genvar k = 0; k < REG_BYTES; k++) begin : g_byte
            localparam int IDX = REG_BYTES - 1 - k;
            logic cnt_hit, thr_hit;
            assign cnt_hit = (reg_addr == cnt_base(l) + 8'(k));
            assign thr_hit = (reg_addr == thr_base(l) + 8'(k));
            assign cnt_rd[l][IDX] = reg_rd && cnt_hit;
            assign thr_rd[l][IDX] = reg_rd && thr_hit;
            assign thr_wr[l][IDX] = reg_wr && thr_hit;
        end
    end

    assign alarm_rd = reg_rd && (reg_addr == ALARM_ADDR);

endmodule

// File: rtl/errcnt_lane.sv
module errcnt_lane
    import errcnt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 err_pulse,
    input  logic                 clr_rd,
    input  logic [REG_BYTES-1:0] thr_wr,
    input  logic [7:0]           wdata,
    output logic [CNT_W-1:0]     cnt_o,
    output logic [CNT_W-1:0]     shadow_o,
    output logic [CNT_W-1:0]     thr_o,
    output logic                 match_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] thr;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic [WIDE_W-1:0] thr_wide;

    always_comb begin
        st_d = st_q;

        // Counting period: a clearing read restarts it, keeping a coincident event.
        if (clr_rd) begin
            st_d.shadow = st_q.cnt;
            st_d.cnt    = err_pulse ? CNT_W'(1) : '0;
        end else if (err_pulse && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end

        // Byte writes to the threshold.
        thr_wide = WIDE_W'(st_q.thr);
        for (int b = 0; b < REG_BYTES; b++) begin
            if (thr_wr[b]) begin
                thr_wide[b*8 +: 8] = wdata;
            end
        end
        st_d.thr = thr_wide[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt    <= '0;
            st_q.shadow <= '0;
            st_q.thr    <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o    = st_q.cnt;
    assign shadow_o = st_q.shadow;
    assign thr_o    = st_q.thr;
    assign match_o  = (st_q.thr != '0) && (st_q.cnt == st_q.thr);

endmodule

// File: rtl/errcnt_alarm.sv
module errcnt_alarm
    import errcnt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       par_err,
    input  logic       hdr_err,
    input  logic [7:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata
);
    typedef struct packed {
        logic [NUM_LANES-1:0] alarm;
        logic [7:0]           rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NUM_LANES-1:0]                 err_vec;
    logic [NUM_LANES-1:0][REG_BYTES-1:0]  cnt_rd, thr_rd, thr_wr;
    logic                                 alarm_rd;
    logic [NUM_LANES-1:0]                 cnt_clr;
    logic [NUM_LANES-1:0]                 lane_match;
    logic [NUM_LANES-1:0][CNT_W-1:0]      cnt_live, cnt_shadow, thr_val;
    logic [NUM_LANES-1:0]                 alarm_q;

    assign err_vec[LANE_PAR] = par_err;
    assign err_vec[LANE_HDR] = hdr_err;

    errcnt_decode u_decode (
        .reg_addr (reg_addr),
        .reg_rd   (reg_rd),
        .reg_wr   (reg_wr),
        .cnt_rd   (cnt_rd),
        .thr_rd   (thr_rd),
        .thr_wr   (thr_wr),
        .alarm_rd (alarm_rd)
    );

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        assign cnt_clr[l] = cnt_rd[l][REG_BYTES-1];

        errcnt_lane #(.CNT_W(CNT_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .err_pulse (err_vec[l]),
            .clr_rd    (cnt_clr[l]),
            .thr_wr    (thr_wr[l]),
            .wdata     (reg_wdata),
            .cnt_o     (cnt_live[l]),
            .shadow_o  (cnt_shadow[l]),
            .thr_o     (thr_val[l]),
            .match_o   (lane_match[l])
        );
    end

    always_comb begin
        st_d = st_q;

        // Sticky alarms: a read clears them unless the match persists.
        st_d.alarm = (st_q.alarm & ~{NUM_LANES{alarm_rd}}) | lane_match;

        // Registered read data; unmapped addresses give zero.
        st_d.rdata = '0;
        for (int l = 0; l < NUM_LANES; l++) begin
            for (int b = 0; b < REG_BYTES; b++) begin
                if (cnt_rd[l][b]) begin
                    st_d.rdata = (b == REG_BYTES - 1)
                               ? byte_of(WIDE_W'(cnt_live[l]), b)
                               : byte_of(WIDE_W'(cnt_shadow[l]), b);
                end
                if (thr_rd[l][b]) begin
                    st_d.rdata = byte_of(WIDE_W'(thr_val[l]), b);
                end
            end
        end
        if (alarm_rd) begin
            st_d.rdata = 8'(st_q.alarm);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alarm_q   = st_q.alarm;
    assign reg_rdata = st_q.rdata;

endmodule

// File: rtl/errcnt_alarm_chk.sv
module errcnt_alarm_chk
    import errcnt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            reg_rd,
    input logic [7:0]                      reg_addr,
    input logic [7:0]                      reg_rdata,
    input logic [NUM_LANES-1:0]            err_vec,
    input logic [NUM_LANES-1:0]            cnt_clr,
    input logic [NUM_LANES-1:0][CNT_W-1:0] cnt_live,
    input logic [NUM_LANES-1:0]            lane_match,
    input logic [NUM_LANES-1:0]            alarm_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic mapped, alarm_read;
    assign mapped     = (reg_addr >= 8'h2E) && (reg_addr <= ALARM_ADDR);
    assign alarm_read = reg_rd && (reg_addr == ALARM_ADDR);

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
            (!cnt_clr[l] && err_vec[l] && cnt_live[l] != CNT_MAX)
            |=> cnt_live[l] == CNT_W'($past(cnt_live[l]) + CNT_W'(1)));

        a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (!cnt_clr[l] && cnt_live[l] == CNT_MAX) |=> cnt_live[l] == CNT_MAX);

        a_r4_clear_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_clr[l] && err_vec[l]) |=> cnt_live[l] == CNT_W'(1));

        a_r6_alarm_set: assert property (@(posedge clk) disable iff (!rst_n)
            lane_match[l] |=> alarm_q[l]);

        a_r7_alarm_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (alarm_q[l] && !alarm_read) |=> alarm_q[l]);
    end

    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !mapped) |=> reg_rdata == 8'h00);

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_read |=> reg_rdata[7:2] == 6'd0);

endmodule

bind errcnt_alarm errcnt_alarm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .err_vec    (err_vec),
    .cnt_clr    (cnt_clr),
    .cnt_live   (cnt_live),
    .lane_match (lane_match),
    .alarm_q    (alarm_q)
);

// File: tb/errcnt_alarm_tb.sv
module errcnt_alarm_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       par_err = 1'b0, hdr_err = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_addr = '0, reg_wdata = '0;
    logic [7:0] reg_rdata;

    logic       s_par = 1'b0, s_rd = 1'b0;
    logic [7:0] s_addr = '0;
    logic [7:0] s_rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    errcnt_alarm u_dut (
        .clk(clk), .rst_n(rst_n), .par_err(par_err), .hdr_err(hdr_err),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    errcnt_alarm #(.CNT_W(8)) u_dut_small (
        .clk(clk), .rst_n(rst_n), .par_err(s_par), .hdr_err(1'b0),
        .reg_addr(s_addr), .reg_wr(1'b0), .reg_rd(s_rd),
        .reg_wdata(8'h00), .reg_rdata(s_rdata)
    );

    // Reference model, index 0 = parity stream, 1 = header stream.
    logic [23:0] m_cnt [2];
    logic [23:0] m_sh  [2];
    logic [23:0] m_thr [2];
    logic [1:0]  m_al;

    function automatic logic [7:0] cbase(int l);
        return (l == 1) ? 8'h2E : 8'h34;
    endfunction

    function automatic logic [7:0] tbase(int l);
        return (l == 1) ? 8'h31 : 8'h37;
    endfunction

    function automatic string tag_of(logic [7:0] a);
        if (a >= 8'h2E && a <= 8'h30) return "R3";
        if (a >= 8'h34 && a <= 8'h36) return "R3";
        if (a >= 8'h31 && a <= 8'h33) return "R5";
        if (a >= 8'h37 && a <= 8'h39) return "R5";
        if (a == 8'h3A) return "R7";
        return "R9";
    endfunction

    function automatic logic [7:0] exp_read(logic [7:0] a);
        for (int l = 0; l < 2; l++) begin
            if (a >= cbase(l) && a < cbase(l) + 8'd3) begin
                int k = int'(a - cbase(l));
                logic [23:0] v = (k == 0) ? m_cnt[l] : m_sh[l];
                return v[(2-k)*8 +: 8];
            end
            if (a >= tbase(l) && a < tbase(l) + 8'd3) begin
                int k = int'(a - tbase(l));
                return m_thr[l][(2-k)*8 +: 8];
            end
        end
        if (a == 8'h3A) return {6'd0, m_al};
        return 8'h00;
    endfunction

    task automatic check(logic [7:0] act, logic [7:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int l = 0; l < 2; l++) begin
            m_cnt[l] = '0; m_sh[l] = '0; m_thr[l] = 24'hFFFFFF;
        end
        m_al = '0;
    endtask

    // One cycle on the main instance; a read is checked after the closing edge.
    task automatic cyc(bit p, bit h, bit rd, bit wr, logic [7:0] a, logic [7:0] wd,
                       string tag = "");
        logic [7:0]  exp;
        logic [23:0] n_cnt [2];
        logic [23:0] n_sh  [2];
        logic [23:0] n_thr [2];
        logic [1:0]  n_al;
        @(negedge clk);
        par_err = p; hdr_err = h; reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        exp = exp_read(a);
        for (int l = 0; l < 2; l++) begin
            bit ev = (l == 1) ? h : p;
            bit mt = (m_thr[l] != 0) && (m_cnt[l] == m_thr[l]);
            n_al[l]  = (m_al[l] && !(rd && a == 8'h3A)) || mt;
            n_cnt[l] = m_cnt[l]; n_sh[l] = m_sh[l]; n_thr[l] = m_thr[l];
            if (rd && a == cbase(l)) begin
                n_sh[l]  = m_cnt[l];
                n_cnt[l] = ev ? 24'd1 : 24'd0;
            end else if (ev && m_cnt[l] != 24'hFFFFFF) begin
                n_cnt[l] = m_cnt[l] + 24'd1;
            end
            if (wr && a >= tbase(l) && a < tbase(l) + 8'd3) begin
                int k = int'(a - tbase(l));
                n_thr[l][(2-k)*8 +: 8] = wd;
            end
        end
        @(posedge clk);
        #1;
        if (rd) check(reg_rdata, exp, (tag == "") ? tag_of(a) : tag);
        for (int l = 0; l < 2; l++) begin
            m_cnt[l] = n_cnt[l]; m_sh[l] = n_sh[l]; m_thr[l] = n_thr[l];
        end
        m_al = n_al;
        par_err = 0; hdr_err = 0; reg_rd = 0; reg_wr = 0;
    endtask

    task automatic rd3(logic [7:0] base, string tag);
        for (int k = 0; k < 3; k++) cyc(0, 0, 1, 0, base + 8'(k), 8'h00, tag);
    endtask

    task automatic s_cyc(bit p, bit rd, logic [7:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        s_par = p; s_rd = rd; s_addr = a;
        @(posedge clk);
        #1;
        if (rd) check(s_rdata, exp, tag);
        s_par = 0; s_rd = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check(reg_rdata, 8'h00, "R10");
        rst_n = 1'b1;

        // R10 / R5 reset values
        cyc(0, 0, 1, 0, 8'h3A, 0, "R10");
        rd3(8'h34, "R10");
        rd3(8'h2E, "R10");
        rd3(8'h31, "R5");
        rd3(8'h37, "R5");

        // R1: independent counting, overlapping pulses
        for (int i = 0; i < 7; i++) cyc(1, (i % 2) == 0, 0, 0, 8'h00, 0);
        rd3(8'h34, "R1");
        rd3(8'h2E, "R1");

        // R4: pulse in the clearing read cycle
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 8'h00, 0);
        cyc(1, 0, 1, 0, 8'h34, 0, "R4");
        cyc(0, 0, 1, 0, 8'h36, 0, "R4");
        cyc(0, 0, 1, 0, 8'h34, 0, "R4");
        cyc(0, 0, 1, 0, 8'h36, 0, "R4");

        // R6 / R7: header threshold 4, alarm set, held while matching, then cleared
        cyc(0, 0, 0, 1, 8'h31, 8'h00);
        cyc(0, 0, 0, 1, 8'h32, 8'h00);
        cyc(0, 0, 0, 1, 8'h33, 8'h04);
        rd3(8'h31, "R5");
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, 8'h00, 0);
        cyc(0, 0, 0, 0, 8'h00, 0);
        cyc(0, 0, 1, 0, 8'h3A, 0, "R6");
        cyc(0, 0, 1, 0, 8'h3A, 0, "R7");
        cyc(0, 0, 1, 0, 8'h2E, 0, "R7");
        cyc(0, 0, 1, 0, 8'h3A, 0, "R7");
        cyc(0, 0, 1, 0, 8'h3A, 0, "R7");

        // R8: zero threshold on parity never matches a cleared counter
        cyc(0, 0, 0, 1, 8'h37, 8'h00);
        cyc(0, 0, 0, 1, 8'h38, 8'h00);
        cyc(0, 0, 0, 1, 8'h39, 8'h00);
        cyc(0, 0, 1, 0, 8'h34, 0, "R8");
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 8'h00, 0);
        cyc(0, 0, 1, 0, 8'h3A, 0, "R8");

        // R9: writes to counters, alarm and unmapped addresses have no effect
        for (int i = 0; i < 2; i++) cyc(0, 1, 0, 0, 8'h00, 0);
        cyc(0, 0, 0, 1, 8'h30, 8'h55);
        cyc(0, 0, 0, 1, 8'h3A, 8'hFF);
        cyc(0, 0, 0, 1, 8'h10, 8'hAA);
        cyc(0, 0, 1, 0, 8'h10, 0, "R9");
        cyc(0, 0, 1, 0, 8'h3B, 0, "R9");
        cyc(0, 0, 1, 0, 8'h3A, 0, "R9");
        rd3(8'h2E, "R9");

        // Random mix of events, reads and threshold writes
        for (int i = 0; i < 3000; i++) begin
            bit p = ($urandom % 10) < 4;
            bit h = ($urandom % 10) < 3;
            int r = $urandom % 20;
            if (r < 3) begin
                cyc(p, h, 1, 0, 8'h2E + 8'($urandom % 16), 0);
            end else if (r == 3) begin
                int k = $urandom % 3;
                logic [7:0] base = ($urandom % 2) ? 8'h31 : 8'h37;
                logic [7:0] wd = (k == 2) ? 8'($urandom % 12) : 8'h00;
                cyc(p, h, 0, 1, base + 8'(k), wd);
            end else begin
                cyc(p, h, 0, 0, 8'h00, 0);
            end
        end

        // R2: saturation on the 8-bit instance, then alarm at the 0xFF threshold
        for (int i = 0; i < 300; i++) s_cyc(1, 0, 8'h00, 8'h00, "R2");
        s_cyc(0, 1, 8'h3A, 8'h01, "R6");
        s_cyc(1, 1, 8'h34, 8'h00, "R2");
        s_cyc(0, 1, 8'h35, 8'h00, "R2");
        s_cyc(0, 1, 8'h36, 8'hFF, "R2");
        s_cyc(0, 1, 8'h36, 8'hFF, "R2");
        s_cyc(0, 1, 8'h34, 8'h00, "R4");
        s_cyc(0, 1, 8'h36, 8'h01, "R4");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule